// File: doc/BRIEF.md
# Triple Timer Counter

This peripheral holds three up-counters that run from one shared input clock and are controlled through a small memory-mapped register interface. Software picks a power-of-two prescale for each counter and starts or stops it. Each counter either free-runs across its full range as a continuous timebase, or runs in interval mode, where it returns to zero at a programmed limit and raises a status flag.

Every timer has its own register bank. The banks are interleaved: one register of a given kind for each timer, four bytes apart. Each timer drives an active-high level interrupt, which is its interval flag gated by its enable bit. Reading the status register returns the flag and acknowledges it. The bus takes a single-cycle write and a single-cycle read. Read data is combinational from the address, and the acknowledge side effect takes place at the clock edge of the read.

Top module: `tri_counter_timer`

## Requirements
- R1: After reset, each timer is stopped with count 0. Counter control reads 0x1, clock control reads 0, interval reads all ones over the counter width, and status and enable read 0.
- R2: Timer k (k = 0, 1, 2) has its registers at byte offsets 4*k plus these bases: clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54, enable 0x60. A write to one timer's register leaves the other timers unchanged.
- R3: Clock control holds three fields. Bit 0 enables the prescaler. Bits 4:1 hold N, and with the prescaler on the count advances once every 2^(N+1) input clocks. Bit 5 is a source-select bit that is stored and read back and does not change counting. With the prescaler off, the count advances every clock.
- R4: Counter control bit 0 set to 1 holds the count. Clearing it resumes counting from the held value.
- R5: Writing counter control with bit 4 set clears the count and the prescale phase in that cycle. Bit 4 always reads back 0. Bits 1:0 read back as written.
- R6: When counter control bit 1 is 0 (free-running), the count wraps from 2^W-1 to 0 and does not set the status flag.
- R7: When counter control bit 1 is 1 (interval mode), a count advance made while the count equals the interval register loads 0 instead and sets status bit 0.
- R8: A read of the status register returns the flag in bit 0 and clears it. If an interval event falls in the same cycle as that read, the flag stays set.
- R9: Enable bit 0 is read/write. Timer k's interrupt output is high exactly while its status bit 0 and enable bit 0 are both 1.
- R10: Write bits above each register's width are ignored and read as 0. A write to the count register has no effect, and an unmapped address reads 0.
- R11: The count register returns the live count on every read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe (acknowledges status) |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, zero when unmapped |
| irq | output | NUM_TMR | Per-timer active-high interrupt level |

## Verification
Two situations are hard to reach from the ports. The first is an interval event that lands on the exact cycle of a status read. The stimulus reaches it by keeping intervals short, keeping prescales small, and issuing status reads back to back against a running counter, so such collisions occur many times. The second is the full-range wrap. A dedicated free-running phase leaves one 16-bit counter running for more than 65,536 clocks, then stops it and reads the count and the status flag.

// File: rtl/tct_pkg.sv
package tct_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned EXP_W    = 4;
    localparam int unsigned STRIDE   = 4;

    localparam int unsigned BASE_CLK  = 'h00;
    localparam int unsigned BASE_CCTL = 'h0C;
    localparam int unsigned BASE_CNT  = 'h18;
    localparam int unsigned BASE_IVL  = 'h24;
    localparam int unsigned BASE_ISR  = 'h54;
    localparam int unsigned BASE_IER  = 'h60;

    localparam int unsigned RESTART_BIT = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CLK,
        SEL_CCTL,
        SEL_CNT,
        SEL_IVL,
        SEL_ISR,
        SEL_IER
    } reg_sel_e;

    typedef struct packed {
        logic             src;
        logic [EXP_W-1:0] exp;
        logic             pre_en;
    } clk_ctl_t;

    typedef struct packed {
        logic ivl_mode;
        logic stop;
    } cnt_ctl_t;

    function automatic reg_sel_e decode_sel(input int unsigned a, input int unsigned idx);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == BASE_CLK  + STRIDE * idx) s = SEL_CLK;
        if (a == BASE_CCTL + STRIDE * idx) s = SEL_CCTL;
        if (a == BASE_CNT  + STRIDE * idx) s = SEL_CNT;
        if (a == BASE_IVL  + STRIDE * idx) s = SEL_IVL;
        if (a == BASE_ISR  + STRIDE * idx) s = SEL_ISR;
        if (a == BASE_IER  + STRIDE * idx) s = SEL_IER;
        return s;
    endfunction

endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler
    import tct_pkg::*;
#(
    parameter int unsigned XW = EXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          pre_en,
    input  logic [XW-1:0] exp_n,
    input  logic          clr,
    output logic          tick
);
    localparam int unsigned DIV_W = 2 ** XW;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] last_phase;

    always_comb begin
        span       = (DIV_W + 1)'(1) << (32'(exp_n) + 32'd1);
        last_phase = DIV_W'(span - 1'b1);
        tick       = run && (!pre_en || (phase_q >= last_phase));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (!pre_en) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end

    // R3: with the prescaler on, the division is at least two, so two ticks never sit back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && pre_en && !clr) |=> (!tick || !pre_en));

endmodule

// File: rtl/tct_channel.sv
module tct_channel
    import tct_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq
);
    localparam int unsigned CLK_W  = $bits(clk_ctl_t);
    localparam int unsigned CCTL_W = $bits(cnt_ctl_t);

    reg_sel_e   sel;
    clk_ctl_t   clk_q;
    cnt_ctl_t   cctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ivl_q;
    logic       isr_q;
    logic       ier_q;

    logic       tick;
    logic       restart_wr;
    logic       at_limit;
    logic       evt;
    logic       isr_ack;

    always_comb begin
        sel        = decode_sel(32'(addr), IDX);
        restart_wr = wr_en && (sel == SEL_CCTL) && wdata[RESTART_BIT];
        isr_ack    = rd_en && (sel == SEL_ISR);
        at_limit   = cctl_q.ivl_mode && (cnt_q == ivl_q);
        evt        = tick && at_limit;
    end

    tct_prescaler #(.XW(EXP_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (!cctl_q.stop),
        .pre_en (clk_q.pre_en),
        .exp_n  (clk_q.exp),
        .clr    (restart_wr),
        .tick   (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= '0;
            cctl_q <= '{ivl_mode: 1'b0, stop: 1'b1};
            ivl_q  <= '1;
            ier_q  <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_CLK:  clk_q  <= clk_ctl_t'(wdata[CLK_W-1:0]);
                SEL_CCTL: cctl_q <= cnt_ctl_t'(wdata[CCTL_W-1:0]);
                SEL_IVL:  ivl_q  <= wdata[CNT_W-1:0];
                SEL_IER:  ier_q  <= wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart_wr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= 1'b0;
        end else if (evt) begin
            isr_q <= 1'b1;
        end else if (isr_ack) begin
            isr_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CLK:  rdata[CLK_W-1:0]  = clk_q;
            SEL_CCTL: rdata[CCTL_W-1:0] = cctl_q;
            SEL_CNT:  rdata[CNT_W-1:0]  = cnt_q;
            SEL_IVL:  rdata[CNT_W-1:0]  = ivl_q;
            SEL_ISR:  rdata[0]          = isr_q;
            SEL_IER:  rdata[0]          = ier_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = isr_q & ier_q;

    // R4: a stopped counter holds its count unless it is restarted
    a_r4_stop_holds: assert property (@(posedge clk) disable iff (rst)
        (cctl_q.stop && !restart_wr) |=> (cnt_q == $past(cnt_q)));

    // R5: a restart write leaves the count at zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (rst)
        restart_wr |=> (cnt_q == '0));

    // R7: an interval event returns the count to zero and raises the flag
    a_r7_event_wraps: assert property (@(posedge clk) disable iff (rst)
        (evt && !restart_wr) |=> (cnt_q == '0 && isr_q));

    // R8: an acknowledge with no competing event clears the flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (isr_ack && !evt) |=> !isr_q);

    // R6: a free-running wrap never raises the flag
    a_r6_free_wrap_silent: assert property (@(posedge clk) disable iff (rst)
        (!cctl_q.ivl_mode && !isr_q) |=> !isr_q);

endmodule

// File: rtl/tct_rd_merge.sv
module tct_rd_merge
    import tct_pkg::*;
#(
    parameter int unsigned N = 3
) (
    input  logic [N*REG_W-1:0] lanes,
    input  logic [N-1:0]       lane_hit,
    output logic [REG_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            rdata = rdata | lanes[i*REG_W +: REG_W];
        end
    end

    // R2: no two timers ever answer the same address
    always_comb begin
        a_r2_one_bank: assert ($onehot0(lane_hit));
    end

endmodule

// File: rtl/tri_counter_timer.sv
module tri_counter_timer
    import tct_pkg::*;
#(
    parameter int unsigned NUM_TMR = 3,
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [NUM_TMR-1:0] irq
);
    logic [NUM_TMR*REG_W-1:0] lanes;
    logic [NUM_TMR-1:0]       hit;

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        tct_channel #(
            .CNT_W  (CNT_W),
            .ADDR_W (ADDR_W),
            .IDX    (k)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en),
            .rd_en  (rd_en),
            .addr   (addr),
            .wdata  (wdata),
            .rdata  (lanes[k*REG_W +: REG_W]),
            .irq    (irq[k])
        );
        assign hit[k] = (decode_sel(32'(addr), k) != SEL_NONE);
    end

    tct_rd_merge #(.N(NUM_TMR)) u_merge (
        .lanes    (lanes),
        .lane_hit (hit),
        .rdata    (rdata)
    );

endmodule

// File: tb/tri_counter_timer_tb_top.sv
module tri_counter_timer_tb_top;
    localparam int W  = 16;
    localparam int NT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    wire  [31:0] rdata;
    wire  [NT-1:0] irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tri_counter_timer #(.NUM_TMR(NT), .CNT_W(W), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // register kinds: 0 clk ctl, 1 counter ctl, 2 count, 3 interval, 4 status, 5 enable
    function automatic logic [7:0] reg_addr(int kind, int k);
        int b;
        case (kind)
            0: b = 'h00; 1: b = 'h0C; 2: b = 'h18;
            3: b = 'h24; 4: b = 'h54; default: b = 'h60;
        endcase
        return 8'(b + 4 * k);
    endfunction

    logic [5:0]   m_clk [NT];
    logic         m_stop[NT];
    logic         m_imode[NT];
    logic [W-1:0] m_cnt [NT];
    logic [W-1:0] m_ivl [NT];
    int           m_pre [NT];
    logic         m_isr [NT];
    logic         m_ier [NT];

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] v;
        v = 32'h0;
        for (int k = 0; k < NT; k++) begin
            if (a == reg_addr(0, k)) v = {26'h0, m_clk[k]};
            if (a == reg_addr(1, k)) v = {30'h0, m_imode[k], m_stop[k]};
            if (a == reg_addr(2, k)) v = {16'h0, m_cnt[k]};
            if (a == reg_addr(3, k)) v = {16'h0, m_ivl[k]};
            if (a == reg_addr(4, k)) v = {31'h0, m_isr[k]};
            if (a == reg_addr(5, k)) v = {31'h0, m_ier[k]};
        end
        return v;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < NT; k++) begin
            if (rst) begin
                m_clk[k] = 6'h0; m_stop[k] = 1'b1; m_imode[k] = 1'b0;
                m_cnt[k] = '0; m_ivl[k] = '1; m_pre[k] = 0;
                m_isr[k] = 1'b0; m_ier[k] = 1'b0;
            end else begin
                int  lim;
                bit  adv;
                bit  ev;
                lim = (1 << (int'(m_clk[k][4:1]) + 1)) - 1;
                adv = !m_stop[k] && (!m_clk[k][0] || m_pre[k] >= lim);
                ev  = adv && m_imode[k] && (m_cnt[k] == m_ivl[k]);
                if (!m_clk[k][0]) m_pre[k] = 0;
                else if (!m_stop[k]) m_pre[k] = adv ? 0 : m_pre[k] + 1;
                if (adv) m_cnt[k] = ev ? '0 : m_cnt[k] + 1'b1;
                if (ev) m_isr[k] = 1'b1;
                else if (rd_en && addr == reg_addr(4, k)) m_isr[k] = 1'b0;
                if (wr_en) begin
                    if (addr == reg_addr(0, k)) m_clk[k] = wdata[5:0];
                    if (addr == reg_addr(1, k)) begin
                        m_stop[k]  = wdata[0];
                        m_imode[k] = wdata[1];
                        if (wdata[4]) begin m_cnt[k] = '0; m_pre[k] = 0; end
                    end
                    if (addr == reg_addr(3, k)) m_ivl[k] = wdata[W-1:0];
                    if (addr == reg_addr(5, k)) m_ier[k] = wdata[0];
                end
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R9: interrupt levels compared every cycle
    always @(negedge clk) begin
        if (!rst) begin
            for (int k = 0; k < NT; k++) chk("R9 irq", 32'(irq[k]), 32'(m_isr[k] & m_ier[k]));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(req, rdata, model_read(a));
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rd_lit(logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(req, rdata, exp);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string kind_req(int kind);
        case (kind)
            0: return "R3 clk ctl";
            1: return "R5 cnt ctl";
            2: return "R11 count";
            3: return "R10 interval";
            4: return "R8 status";
            default: return "R9 enable";
        endcase
    endfunction

    initial begin
        #(1_900_000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int k = 0; k < NT; k++) begin
            rd_lit(reg_addr(0, k), 32'h0, "R1 clk ctl");
            rd_lit(reg_addr(1, k), 32'h1, "R1 cnt ctl");
            rd_lit(reg_addr(2, k), 32'h0, "R1 count");
            rd_lit(reg_addr(3, k), 32'hFFFF, "R1 interval");
            rd_lit(reg_addr(4, k), 32'h0, "R1 status");
            rd_lit(reg_addr(5, k), 32'h0, "R1 enable");
        end

        // R2: bank stride, neighbours untouched
        wr(8'h28, 32'h1234);
        rd_lit(8'h28, 32'h1234, "R2 own bank");
        rd_lit(8'h24, 32'hFFFF, "R2 neighbour below");
        rd_lit(8'h2C, 32'hFFFF, "R2 neighbour above");

        // R10: upper bits, read-only count, unmapped address
        wr(8'h24, 32'hABCD_5678);
        rd_lit(8'h24, 32'h5678, "R10 upper bits dropped");
        wr(8'h00, 32'hFFFF_FFFF);
        rd_lit(8'h00, 32'h3F, "R10 clk ctl width");
        wr(8'h00, 32'h0);
        wr(8'h18, 32'h55);
        rd_lit(8'h18, 32'h0, "R10 count read-only");
        rd_lit(8'h30, 32'h0, "R10 unmapped");

        // R7 and R8: interval 3, no prescale, enabled interrupt
        wr(reg_addr(3, 0), 32'd3);
        wr(reg_addr(5, 0), 32'd1);
        wr(reg_addr(1, 0), 32'h12);
        rd_lit(reg_addr(1, 0), 32'h2, "R5 restart bit reads 0");
        idle(20);
        rd(reg_addr(2, 0), "R7 count in interval");
        wr(reg_addr(1, 0), 32'h3);
        rd_lit(reg_addr(4, 0), 32'h1, "R7 flag set");
        rd_lit(reg_addr(4, 0), 32'h0, "R8 flag cleared by read");
        rd(reg_addr(2, 0), "R4 stopped count");
        idle(10);
        rd(reg_addr(2, 0), "R4 count held");
        wr(reg_addr(1, 0), 32'h2);
        idle(2);
        rd(reg_addr(2, 0), "R4 resume");
        // back-to-back status reads against a running short interval
        for (int i = 0; i < 40; i++) rd(reg_addr(4, 0), "R8 status collision");

        // R3: prescale divide-by-4 on timer 1, source bit set
        wr(reg_addr(0, 1), 32'h23);
        wr(reg_addr(1, 1), 32'h10);
        idle(41);
        wr(reg_addr(1, 1), 32'h1);
        rd(reg_addr(2, 1), "R3 prescaled count");
        rd_lit(reg_addr(0, 1), 32'h23, "R3 source bit readback");

        // R6: full-range free-running wrap on timer 2
        wr(reg_addr(1, 2), 32'h10);
        idle(65540);
        wr(reg_addr(1, 2), 32'h1);
        rd(reg_addr(2, 2), "R6 wrapped count");
        rd_lit(reg_addr(4, 2), 32'h0, "R6 no flag on wrap");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int k, kind, op;
            logic [31:0] d;
            k    = $urandom_range(NT - 1);
            kind = $urandom_range(5);
            op   = $urandom_range(9);
            case (kind)
                0: d = {26'h0, 1'($urandom), 4'($urandom_range(2)), 1'($urandom)};
                1: d = {27'h0, 1'($urandom_range(3) == 0), 2'b0,
                        1'($urandom), 1'($urandom_range(3) == 0)};
                3: d = $urandom_range(30) | ($urandom & 32'hFFFF_0000);
                default: d = $urandom;
            endcase
            if (op < 3) wr(reg_addr(kind, k), d);
            else if (op < 9) rd(reg_addr(kind, k), kind_req(kind));
            else idle($urandom_range(6));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule